// File: doc/BRIEF.md
# Serial Register Access Slave Port

This block lets an external serial master reach a bank of 8-bit registers over a four-wire serial link. The link has an active-low select, a serial clock, data-in and a data-out that the block drives only when it has read data to send. The system clock oversamples all three serial inputs, so every decision is taken in the system clock domain. Select, clock and data-in each pass through a short synchronizer before the edge detector sees them.

Each frame starts with a device byte, sent most significant bit first. Its upper seven bits must equal the device identifier, and its lowest bit picks write (0) or read (1). A write frame then carries a pointer byte and any number of data bytes. The pointer byte holds an auto-increment flag in bit 7 and the register pointer in its low bits. The pointer and the flag are kept after the frame ends. A read is done in two frames: a write frame carrying only the pointer byte, then a read frame holding just the device byte. The block streams register contents out for as long as select stays low. Some register slots are read-only views of status inputs, and writes to those slots are dropped.

Top module: `cfg_spi_port`

## Requirements
- R1: After reset, every writable register reads 0, the stored pointer is 0, auto-increment is off and the data-out enable `spi_miso_oe` is low.
- R2: A write frame is the device byte 0x40 (identifier 0x20, bit 0 = 0), then a pointer byte {auto-increment flag in bit 7, pointer in the low bits}, then data bytes, all most significant bit first. Each complete data byte lands in the register at the pointer, and register i appears on `cfg_out[8*i+7:8*i]`.
- R3: With the flag set, each completed data byte written advances the pointer by one, so successive bytes fill successive registers.
- R4: An incremented pointer wraps from the last register (31) back to register 0.
- R5: With the flag clear, every byte in a frame uses the same register, for writes and for reads.
- R6: A read frame is the single device byte 0x41. After its eighth clock, the register at the stored pointer is shifted out most significant bit first. Data-out changes after falling clock edges, so the master samples it on rising edges.
- R7: While select stays low in a read frame, further bytes keep streaming. With the flag set, the pointer advances after each byte read, and it wraps from 31 to 0.
- R8: Register slots marked in `RO_MASK` (default slots 4 to 7) read back `stat_in` (slot 4 in bits 7:0, rising upward). A write to such a slot is dropped, and its `cfg_out` field stays 0.
- R9: A device byte whose upper seven bits differ from 0x20 makes the block ignore the rest of the frame. Nothing is written and data-out stays disabled until select rises.
- R10: `spi_miso_oe` is high only while a read frame is shifting register bits. It drops within a few system clocks after select rises.
- R11: A byte left unfinished when select rises is discarded and writes nothing.
- R12: Only the low five bits of the pointer field address the bank; pointer 0x4A selects register 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, high impedance when disabled |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| stat_in | input | 32 | Status bytes shown in the read-only slots, lowest slot first |
| cfg_out | output | 256 | Contents of all writable registers, register i in byte i |

## Verification
The bench attacks pointer wrap on writes and on streamed reads. A design that saturated at 31 or carried into a sixth bit would fill the wrong register after 31, and a read would return stale bytes. Streaming across the boundary between writable and read-only slots catches a bank that mixes up the status lane ordering or lets a write reach a status slot. Repeated bytes with auto-increment off, a wrong device identifier, a byte cut short by select rising, and a pointer field with high bits set each show up as a changed `cfg_out` byte or an unexpected enable of data-out. They catch a design that advances the pointer anyway, answers another identifier, commits half a byte, or decodes all seven pointer bits.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } spi_state_e;

    typedef struct packed {
        logic csn;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } spi_evt_t;

    function automatic int mask_ones(input logic [63:0] mask, input int upto);
        int n;
        n = 0;
        for (int k = 0; k < upto; k++) begin
            if (mask[k]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge
    import cfg_spi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     csn,
    input  logic     sck,
    input  logic     mosi,
    output spi_evt_t evt
);
    logic [STAGES-1:0] csn_q;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] mosi_q;
    logic              sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q    <= '1;
            sck_q    <= '0;
            mosi_q   <= '0;
            sck_last <= 1'b0;
        end else begin
            csn_q    <= {csn_q[STAGES-2:0], csn};
            sck_q    <= {sck_q[STAGES-2:0], sck};
            mosi_q   <= {mosi_q[STAGES-2:0], mosi};
            sck_last <= sck_q[STAGES-1];
        end
    end

    always_comb begin
        evt.csn      = csn_q[STAGES-1];
        evt.mosi     = mosi_q[STAGES-1];
        evt.sck_rise = sck_q[STAGES-1] & ~sck_last;
        evt.sck_fall = ~sck_q[STAGES-1] & sck_last;
    end

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
    import cfg_spi_pkg::*;
#(
    parameter int         ADDR_W = 5,
    parameter logic [6:0] DEV_ID = 7'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [7:0]        wdata,
    output logic              miso,
    output logic              miso_oe
);
    spi_state_e        state;
    logic [2:0]        rcnt;
    logic [6:0]        rsh;
    logic [7:0]        rx_byte;
    logic [ADDR_W-1:0] ptr;
    logic              ai;
    logic [7:0]        tsh;
    logic [2:0]        tcnt;
    logic              byte_done;

    assign rx_byte   = {rsh, evt.mosi};
    assign byte_done = evt.sck_rise && (rcnt == 3'd7);

    assign we      = (state == ST_WDATA) && byte_done && !evt.csn;
    assign waddr   = ptr;
    assign wdata   = rx_byte;
    assign raddr   = ptr + ADDR_W'(miso_oe && ai);
    assign miso    = tsh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rcnt    <= '0;
            rsh     <= '0;
            ptr     <= '0;
            ai      <= 1'b0;
            tsh     <= '0;
            tcnt    <= '0;
            miso_oe <= 1'b0;
        end else if (evt.csn) begin
            state   <= ST_IDLE;
            rcnt    <= '0;
            miso_oe <= 1'b0;
        end else begin
            if (evt.sck_rise) begin
                rsh  <= rx_byte[6:0];
                rcnt <= rcnt + 3'd1;
            end
            unique case (state)
                ST_IDLE: begin
                    state <= ST_ADDR;
                    rcnt  <= '0;
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        if (rx_byte[7:1] != DEV_ID) state <= ST_SKIP;
                        else if (rx_byte[0])        state <= ST_RDATA;
                        else                        state <= ST_PTR;
                    end
                end
                ST_PTR: begin
                    if (byte_done) begin
                        ai    <= rx_byte[7];
                        ptr   <= rx_byte[ADDR_W-1:0];
                        state <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (byte_done && ai) ptr <= ptr + 1'b1;
                end
                ST_RDATA: begin
                    if (evt.sck_fall) begin
                        if (!miso_oe) begin
                            miso_oe <= 1'b1;
                            tsh     <= rdata;
                            tcnt    <= '0;
                        end else if (tcnt == 3'd7) begin
                            tsh  <= rdata;
                            tcnt <= '0;
                            ptr  <= raddr;
                        end else begin
                            tsh  <= {tsh[6:0], 1'b0};
                            tcnt <= tcnt + 3'd1;
                        end
                    end
                end
                ST_SKIP: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (state == ST_RDATA)); // R10

    AST_HIZ_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
        evt.csn |=> !miso_oe); // R10

    AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !we); // R9

    AST_WRITE_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (we && ai) |=> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R3

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_spi_pkg::*;
#(
    parameter int               NREGS   = 32,
    parameter logic [NREGS-1:0] RO_MASK = 32'h0000_00F0,
    parameter int               NUM_RO  = 4,
    localparam int              ADDR_W  = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [7:0]          wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [7:0]          rdata,
    input  logic [NUM_RO*8-1:0] stat_in,
    output logic [NREGS*8-1:0]  cfg_out
);
    logic [7:0] view [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        if (RO_MASK[gi]) begin : g_ro
            localparam int LANE = mask_ones(64'(RO_MASK), gi);
            assign view[gi]          = stat_in[LANE*8 +: 8];
            assign cfg_out[gi*8 +: 8] = 8'h00;
        end else begin : g_rw
            logic [7:0] store;
            always_ff @(posedge clk) begin
                if (rst)                                    store <= 8'h00;
                else if (we && (waddr == ADDR_W'(gi)))      store <= wdata;
            end
            assign view[gi]           = store;
            assign cfg_out[gi*8 +: 8] = store;
        end
    end

    assign rdata = view[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && !RO_MASK[waddr]) |=> (cfg_out[$past(waddr)*8 +: 8] == $past(wdata))); // R2

endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int               NREGS       = 32,
    parameter logic [6:0]       DEV_ID      = 7'h20,
    parameter logic [NREGS-1:0] RO_MASK     = 32'h0000_00F0,
    parameter int               SYNC_STAGES = 2,
    localparam int              ADDR_W      = $clog2(NREGS),
    localparam int              NUM_RO      = mask_ones(64'(RO_MASK), NREGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_csn,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    input  logic [NUM_RO*8-1:0] stat_in,
    output logic [NREGS*8-1:0]  cfg_out
);
    spi_evt_t          evt;
    logic [7:0]        rdata;
    logic [ADDR_W-1:0] raddr;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [7:0]        wdata;
    logic              miso_bit;

    spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .csn  (spi_csn),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_frame_ctl #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rdata   (rdata),
        .raddr   (raddr),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .miso    (miso_bit),
        .miso_oe (spi_miso_oe)
    );

    cfg_regbank #(.NREGS(NREGS), .RO_MASK(RO_MASK), .NUM_RO(NUM_RO)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr   (raddr),
        .rdata   (rdata),
        .stat_in (stat_in),
        .cfg_out (cfg_out)
    );

    assign spi_miso = spi_miso_oe ? miso_bit : 1'bz;

endmodule

// File: tb/cfg_spi_port_tb.sv
module cfg_spi_port_tb;
    localparam int H = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         spi_csn = 1'b1;
    logic         spi_sck = 1'b0;
    logic         spi_mosi = 1'b0;
    logic         spi_miso;
    logic         spi_miso_oe;
    logic [31:0]  stat_in = {8'hD7, 8'hC6, 8'hC5, 8'hC4};
    logic [255:0] cfg_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] acc;
    int         nbit;
    bit         oe_seen;

    always #4 clk = ~clk;

    cfg_spi_port u_dut (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .stat_in(stat_in), .cfg_out(cfg_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: assemble bytes seen on data-out and compare with the scoreboard
    always @(posedge spi_sck or posedge spi_csn) begin
        if (spi_csn) begin
            nbit = 0;
        end else if (spi_miso_oe) begin
            acc = {acc[6:0], spi_miso};
            nbit++;
            if (nbit == 8) begin
                nbit = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected read byte", {24'h0, acc}, 32'h0);
                end else begin
                    chk(acc == exp_q[0], tag_q[0], {24'h0, acc}, {24'h0, exp_q[0]});
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    always @(posedge clk) if (spi_miso_oe) oe_seen = 1'b1;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = b[i];
            wait_clk(H);
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_csn = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_high();
        wait_clk(H);
        spi_csn = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic wr_frame(input logic [7:0] dev, input logic [7:0] pb,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int nd);
        cs_low();
        send_bits(dev, 8);
        send_bits(pb, 8);
        if (nd > 0) send_bits(d0, 8);
        if (nd > 1) send_bits(d1, 8);
        if (nd > 2) send_bits(d2, 8);
        cs_high();
    endtask

    task automatic rd_frame(input logic [7:0] e0, input logic [7:0] e1,
                            input logic [7:0] e2, input int nr, input string tag);
        if (nr > 0) begin exp_q.push_back(e0); tag_q.push_back(tag); end
        if (nr > 1) begin exp_q.push_back(e1); tag_q.push_back(tag); end
        if (nr > 2) begin exp_q.push_back(e2); tag_q.push_back(tag); end
        cs_low();
        send_bits(8'h41, 8);
        for (int k = 0; k < nr; k++) send_bits(8'h00, 8);
        cs_high();
        chk(exp_q.size() == 0, {tag, " bytes left unread"}, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    function automatic logic [7:0] reg_of(input int i);
        return cfg_out[i*8 +: 8];
    endfunction

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1 reset state
        chk(spi_miso_oe == 1'b0, "R1 oe after reset", spi_miso_oe, 0);
        chk(cfg_out == '0, "R1 registers after reset", cfg_out[31:0], 0);
        rd_frame(8'h00, 8'h00, 8'h00, 2, "R1 read reg0 after reset");

        // R2 R3 auto-increment write
        wr_frame(8'h40, 8'h88, 8'h11, 8'h22, 8'h33, 3);
        chk(reg_of(8) == 8'h11, "R2 reg8", reg_of(8), 8'h11);
        chk(reg_of(9) == 8'h22, "R3 reg9", reg_of(9), 8'h22);
        chk(reg_of(10) == 8'h33, "R3 reg10", reg_of(10), 8'h33);

        // R4 write wrap
        wr_frame(8'h40, 8'h9E, 8'h5A, 8'h6B, 8'h7C, 3);
        chk(reg_of(30) == 8'h5A, "R4 reg30", reg_of(30), 8'h5A);
        chk(reg_of(31) == 8'h6B, "R4 reg31", reg_of(31), 8'h6B);
        chk(reg_of(0) == 8'h7C, "R4 reg0 after wrap", reg_of(0), 8'h7C);

        // R5 auto-increment clear on write
        wr_frame(8'h40, 8'h0C, 8'h01, 8'h02, 8'h03, 3);
        chk(reg_of(12) == 8'h03, "R5 reg12 last byte", reg_of(12), 8'h03);
        chk(reg_of(13) == 8'h00, "R5 reg13 untouched", reg_of(13), 8'h00);

        // R6 R7 reads
        wr_frame(8'h40, 8'h88, 8'h00, 8'h00, 8'h00, 0);
        rd_frame(8'h11, 8'h22, 8'h33, 3, "R6 R7 read reg8..10");
        chk(spi_miso_oe == 1'b0, "R10 oe after read frame", spi_miso_oe, 0);
        wr_frame(8'h40, 8'h9E, 8'h00, 8'h00, 8'h00, 0);
        rd_frame(8'h5A, 8'h6B, 8'h7C, 3, "R7 read wrap 30,31,0");
        wr_frame(8'h40, 8'h0C, 8'h00, 8'h00, 8'h00, 0);
        rd_frame(8'h03, 8'h03, 8'h00, 2, "R5 read repeat reg12");

        // R8 read-only slots
        wr_frame(8'h40, 8'h05, 8'hFF, 8'h00, 8'h00, 1);
        chk(reg_of(5) == 8'h00, "R8 ro slot cfg_out", reg_of(5), 8'h00);
        wr_frame(8'h40, 8'h05, 8'h00, 8'h00, 8'h00, 0);
        rd_frame(8'hC5, 8'h00, 8'h00, 1, "R8 read status slot5");
        wr_frame(8'h40, 8'h83, 8'h00, 8'h00, 8'h00, 0);
        rd_frame(8'h00, 8'hC4, 8'hC5, 3, "R8 stream reg3 into status");

        // R9 device identifier mismatch
        oe_seen = 1'b0;
        wr_frame(8'h42, 8'h08, 8'hEE, 8'h00, 8'h00, 1);
        chk(reg_of(8) == 8'h11, "R9 mismatched write ignored", reg_of(8), 8'h11);
        cs_low();
        send_bits(8'h43, 8);
        send_bits(8'h00, 8);
        send_bits(8'h00, 8);
        cs_high();
        chk(oe_seen == 1'b0, "R9 R10 oe stayed low on mismatch", oe_seen, 0);

        // R10 oe never raised during write frame
        oe_seen = 1'b0;
        wr_frame(8'h40, 8'h0F, 8'hAB, 8'h00, 8'h00, 1);
        chk(oe_seen == 1'b0, "R10 oe low during write", oe_seen, 0);

        // R11 partial byte discarded
        cs_low();
        send_bits(8'h40, 8);
        send_bits(8'h0F, 8);
        send_bits(8'hF0, 4);
        cs_high();
        chk(reg_of(15) == 8'hAB, "R11 partial byte discarded", reg_of(15), 8'hAB);

        // R12 pointer upper bits ignored
        wr_frame(8'h40, 8'h4A, 8'h77, 8'h00, 8'h00, 1);
        chk(reg_of(10) == 8'h77, "R12 pointer 0x4A hits reg10", reg_of(10), 8'h77);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule